// File: doc/BRIEF.md
# Multi-Channel Compare Timer Bank

A bank of up to six independent up-counting timer channels reached through a plain word-addressed register port (address, write data, write strobe, combinational read data). Each channel owns a window of four words: a control word that starts, stops and clears the counter and picks its operating mode; a tick-configuration word that picks one of two tick-enable inputs and an optional divide-by-two; the live counter; and a compare value. A channel counts selected ticks upward. When a step brings the counter onto the compare value, the channel raises its pending flag. Depending on the mode, it then halts, restarts from zero, or ignores compare altogether.

Window 0 holds the two words that all channels share. One is an interrupt mask. The other reads back the raw pending flags, and a write to it clears every flag whose data bit is one. The block drives one interrupt line, which is high while any pending flag is unmasked. The tick inputs are single-cycle enables in the block's own clock domain. No clock is switched.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset, every readable word is zero and irq is low: mask, pending flags, each channel's control, tick configuration, counter and compare.
- R2: The bus is word-addressed. Word 4n+0 is channel n's control, 4n+1 its tick configuration, 4n+2 its counter, 4n+3 its compare (n = 1..NUM_CH). Word 0 is the interrupt mask, with bit n-1 for channel n. Word 2 is pending/acknowledge. Other words and windows above NUM_CH read zero, and writes to them are dropped.
- R3: In control, bit 0 is run and bits [5:4] are mode (0 one-shot, 1 repeat, 3 free-running). In one-shot, a step that makes the counter equal to compare sets pending, leaves the counter at compare, and clears run.
- R4: Mode code 2 behaves exactly like one-shot.
- R5: In repeat mode, the matching step loads the counter with zero, sets pending and leaves run set. A match therefore recurs every compare steps.
- R6: In free-running mode, the counter passes the compare value without setting pending and wraps at 2^CNT_W.
- R7: Writing control with bit 1 set zeroes the counter at that write edge, even if a step was due, and restarts the divider phase. Bit 1 is not stored and reads back 0.
- R8: Tick-configuration bit 0 = 0 steps on every selected tick. Bit 0 = 1 steps on every second selected tick, the first step coming on the second tick after a clear.
- R9: Tick-configuration bit 4 = 0 counts fast_tick and bit 4 = 1 counts slow_tick. The input that is not selected has no effect.
- R10: With run clear, the counter holds its value, and a control write with bit 0 = 0 keeps the mode it writes visible in the read-back.
- R11: The counter word is read-only: a write to it leaves the count unchanged.
- R12: irq is high exactly while some channel has both its pending flag and its mask bit set. With a zero mask, irq stays low.
- R13: Writing word 2 clears pending flags whose data bit is 1 and leaves flags whose data bit is 0. A match in the same cycle as the clearing write leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fast_tick | input | 1 | Fast tick enable, one clock wide per tick |
| slow_tick | input | 1 | Slow tick enable, one clock wide per tick |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write strobe, one write per cycle |
| rdata | output | DATA_W | Read data for addr, combinational |
| irq | output | 1 | Combined masked interrupt |

## Verification
The properties assume that a write to one channel's control word is the only thing that can override that channel's counter or run bit in a cycle. They also assume that the tick inputs and bus signals are stable around the rising edge. The stimulus changes addr, wdata, we and both tick inputs only on the falling edge, and it holds we for exactly one cycle per access. Every property that concerns a match or an idle channel is gated by the control-write strobe of that channel. The bench therefore leaves them in force while it restarts channels, including a restart that lands on the same edge as a due step.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_LOOP = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_FREE = 2'd3
  } gpt_mode_e;

  // word offsets inside a channel window
  localparam logic [1:0] SUB_CTRL = 2'd0;
  localparam logic [1:0] SUB_CFG  = 2'd1;
  localparam logic [1:0] SUB_CNT  = 2'd2;
  localparam logic [1:0] SUB_CMP  = 2'd3;

  // word offsets inside the shared window 0
  localparam logic [1:0] GSUB_MASK = 2'd0;
  localparam logic [1:0] GSUB_PEND = 2'd2;

  // field positions
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CFG_DIV_BIT   = 0;
  localparam int CFG_SRC_BIT   = 4;

endpackage

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_tick,
  input  logic slow_tick,
  input  logic src_slow,
  input  logic div_half,
  input  logic run,
  input  logic restart,
  output logic step
);

  logic phase_q;
  logic phase_d;
  logic sel_tick;

  always_comb begin
    sel_tick = src_slow ? slow_tick : fast_tick;
    phase_d  = phase_q;
    step     = 1'b0;
    if (restart) begin
      phase_d = 1'b0;
    end else if (run && sel_tick) begin
      phase_d = ~phase_q;
      step    = !div_half || phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic             ctrl_wr,
  input  logic             cfg_wr,
  input  logic             cmp_wr,
  input  logic             wr_run,
  input  logic             wr_clr,
  input  logic [1:0]       wr_mode,
  input  logic             wr_src,
  input  logic             wr_div,
  input  logic [CNT_W-1:0] wr_cmp,
  output logic             run,
  output logic [1:0]       mode,
  output logic             src,
  output logic             div,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             match
);

  logic             run_q, run_d;
  gpt_mode_e        mode_q, mode_d;
  logic             src_q, src_d;
  logic             div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             clr;
  logic             step;
  logic             is_free;
  logic             is_loop;

  assign clr = ctrl_wr && wr_clr;

  gpt_tick_gen u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .src_slow  (src_q),
    .div_half  (div_q),
    .run       (run_q),
    .restart   (clr),
    .step      (step)
  );

  always_comb begin
    is_free = (mode_q == MODE_FREE);
    is_loop = (mode_q == MODE_LOOP);
    cnt_inc = cnt_q + 1'b1;
    match   = step && !clr && !is_free && (cnt_inc == cmp_q);

    // counter: clear beats step, repeat reloads zero on its match
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = (match && is_loop) ? '0 : cnt_inc;
    end

    // run bit: software write beats the one-shot halt
    run_d = run_q;
    if (ctrl_wr) begin
      run_d = wr_run;
    end else if (match && !is_loop) begin
      run_d = 1'b0;
    end

    mode_d = ctrl_wr ? gpt_mode_e'(wr_mode) : mode_q;
    src_d  = cfg_wr ? wr_src : src_q;
    div_d  = cfg_wr ? wr_div : div_q;
    cmp_d  = cmp_wr ? wr_cmp : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= MODE_ONCE;
      src_q  <= 1'b0;
      div_q  <= 1'b0;
      cnt_q  <= '0;
      cmp_q  <= '0;
    end else begin
      run_q  <= run_d;
      mode_q <= mode_d;
      src_q  <= src_d;
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
    end
  end

  assign run  = run_q;
  assign mode = mode_q;
  assign src  = src_q;
  assign div  = div_q;
  assign cnt  = cnt_q;
  assign cmp  = cmp_q;

endmodule

// File: rtl/gpt_irq_ctrl.sv
module gpt_irq_ctrl #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic              ack_wr,
  input  logic [NUM_CH-1:0] wr_bits,
  input  logic [NUM_CH-1:0] match,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] pend,
  output logic              irq
);

  logic [NUM_CH-1:0] mask_q, mask_d;
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [NUM_CH-1:0] ack_bits;

  always_comb begin
    ack_bits = ack_wr ? wr_bits : '0;
    pend_d   = (pend_q & ~ack_bits) | match;
    mask_d   = mask_wr ? wr_bits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign mask = mask_q;
  assign pend = pend_q;
  assign irq  = |(pend_q & mask_q);

endmodule

// File: rtl/gpt_bus_decode.sv
module gpt_bus_decode
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              glob_sel,
  output logic [NUM_CH-1:0] ch_sel,
  output logic [1:0]        sub,
  output logic              mask_wr,
  output logic              ack_wr,
  output logic [NUM_CH-1:0] ctrl_wr,
  output logic [NUM_CH-1:0] cfg_wr,
  output logic [NUM_CH-1:0] cmp_wr
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] win;

  assign win      = addr[ADDR_W-1:2];
  assign sub      = addr[1:0];
  assign glob_sel = (win == '0);
  assign mask_wr  = we && glob_sel && (sub == GSUB_MASK);
  assign ack_wr   = we && glob_sel && (sub == GSUB_PEND);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_win
    assign ch_sel[i]  = (win == IDX_W'(i + 1));
    assign ctrl_wr[i] = we && ch_sel[i] && (sub == SUB_CTRL);
    assign cfg_wr[i]  = we && ch_sel[i] && (sub == SUB_CFG);
    assign cmp_wr[i]  = we && ch_sel[i] && (sub == SUB_CMP);
  end

endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic rst_meta_n;
  logic rst_q_n;

  logic                        glob_sel;
  logic [NUM_CH-1:0]           ch_sel;
  logic [1:0]                  sub;
  logic                        mask_wr;
  logic                        ack_wr;
  logic [NUM_CH-1:0]           ctrl_wr;
  logic [NUM_CH-1:0]           cfg_wr;
  logic [NUM_CH-1:0]           cmp_wr;

  logic [NUM_CH-1:0]           ch_run;
  logic [NUM_CH-1:0][1:0]      ch_mode;
  logic [NUM_CH-1:0]           ch_src;
  logic [NUM_CH-1:0]           ch_div;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cmp;
  logic [NUM_CH-1:0]           ch_match;
  logic [NUM_CH-1:0]           mask_q;
  logic [NUM_CH-1:0]           pend_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  gpt_bus_decode #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_dec (
    .addr     (addr),
    .we       (we),
    .glob_sel (glob_sel),
    .ch_sel   (ch_sel),
    .sub      (sub),
    .mask_wr  (mask_wr),
    .ack_wr   (ack_wr),
    .ctrl_wr  (ctrl_wr),
    .cfg_wr   (cfg_wr),
    .cmp_wr   (cmp_wr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    gpt_channel #(
      .CNT_W (CNT_W)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .ctrl_wr   (ctrl_wr[i]),
      .cfg_wr    (cfg_wr[i]),
      .cmp_wr    (cmp_wr[i]),
      .wr_run    (wdata[CTRL_RUN_BIT]),
      .wr_clr    (wdata[CTRL_CLR_BIT]),
      .wr_mode   (wdata[CTRL_MODE_LSB +: 2]),
      .wr_src    (wdata[CFG_SRC_BIT]),
      .wr_div    (wdata[CFG_DIV_BIT]),
      .wr_cmp    (wdata[CNT_W-1:0]),
      .run       (ch_run[i]),
      .mode      (ch_mode[i]),
      .src       (ch_src[i]),
      .div       (ch_div[i]),
      .cnt       (ch_cnt[i]),
      .cmp       (ch_cmp[i]),
      .match     (ch_match[i])
    );
  end

  gpt_irq_ctrl #(
    .NUM_CH (NUM_CH)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .mask_wr (mask_wr),
    .ack_wr  (ack_wr),
    .wr_bits (wdata[NUM_CH-1:0]),
    .match   (ch_match),
    .mask    (mask_q),
    .pend    (pend_q),
    .irq     (irq)
  );

  always_comb begin
    rdata = '0;
    if (glob_sel) begin
      case (sub)
        GSUB_MASK: rdata = DATA_W'(mask_q);
        GSUB_PEND: rdata = DATA_W'(pend_q);
        default:   rdata = '0;
      endcase
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) begin
        case (sub)
          SUB_CTRL: begin
            rdata[CTRL_RUN_BIT]        = ch_run[i];
            rdata[CTRL_MODE_LSB +: 2]  = ch_mode[i];
          end
          SUB_CFG: begin
            rdata[CFG_DIV_BIT] = ch_div[i];
            rdata[CFG_SRC_BIT] = ch_src[i];
          end
          SUB_CNT: rdata = DATA_W'(ch_cnt[i]);
          default: rdata = DATA_W'(ch_cmp[i]);
        endcase
      end
    end
  end

endmodule

// File: rtl/gp_timer_bank_chk.sv
module gp_timer_bank_chk
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         irq,
  input logic [NUM_CH-1:0]            pend,
  input logic [NUM_CH-1:0]            mask,
  input logic [NUM_CH-1:0]            run,
  input logic [NUM_CH-1:0][1:0]       mode,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0]            match,
  input logic [NUM_CH-1:0]            ctrl_wr,
  input logic                         ack_wr,
  input logic [NUM_CH-1:0]            ack_bits
);

  // R12: a fully masked bank never interrupts
  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R13: a match always leaves the flag set, acknowledge or not
    a_r13_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
      match[i] |=> pend[i]);

    // R13: acknowledge without a racing match clears the flag
    a_r13_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && ack_bits[i] && !match[i]) |=> !pend[i]);

    // R3 / R4: one-shot and reserved halt on match
    a_r3_once_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (match[i] && (mode[i] != 2'(MODE_LOOP)) && !ctrl_wr[i]) |=> !run[i]);

    // R5: repeat reloads zero and keeps running
    a_r5_loop_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (match[i] && (mode[i] == 2'(MODE_LOOP)) && !ctrl_wr[i])
        |=> (cnt[i] == '0) && run[i]);

    // R6: free-running never matches
    a_r6_free_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == 2'(MODE_FREE)) |-> !match[i]);

    // R10: a stopped channel holds its count
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !ctrl_wr[i]) |=> $stable(cnt[i]));
  end

endmodule

bind gp_timer_bank gp_timer_bank_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .irq      (irq),
  .pend     (pend_q),
  .mask     (mask_q),
  .run      (ch_run),
  .mode     (ch_mode),
  .cnt      (ch_cnt),
  .match    (ch_match),
  .ctrl_wr  (ctrl_wr),
  .ack_wr   (ack_wr),
  .ack_bits (wdata[NUM_CH-1:0])
);

// File: tb/gp_timer_bank_test.sv
`timescale 1ns/1ps
module gp_timer_bank_test;

  localparam int AW = 6;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_MASK = 6'd0;
  localparam logic [AW-1:0] A_PEND = 6'd2;

  logic          clk;
  logic          rst_n;
  logic          fast_tick;
  logic          slow_tick;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          we;
  logic [DW-1:0] rdata;
  logic          irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  gp_timer_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .addr      (addr),
    .wdata     (wdata),
    .we        (we),
    .rdata     (rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [31:0] ch;
    logic [31:0] mode;
    logic [31:0] div;
    logic [31:0] cmp;
    logic [31:0] cyc;
    logic [31:0] ecnt;
    logic [31:0] epend;
    logic [31:0] erun;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'd1, 32'd0, 32'd0, 32'd5, 32'd7,  32'd5, 32'd1, 32'd0},  // R3 one-shot
    '{32'd2, 32'd1, 32'd0, 32'd4, 32'd6,  32'd2, 32'd1, 32'd1},  // R5 repeat
    '{32'd3, 32'd3, 32'd0, 32'd3, 32'd9,  32'd9, 32'd0, 32'd1},  // R6 free
    '{32'd4, 32'd0, 32'd1, 32'd8, 32'd10, 32'd5, 32'd0, 32'd1},  // R8 half rate
    '{32'd5, 32'd2, 32'd0, 32'd3, 32'd6,  32'd3, 32'd1, 32'd0},  // R4 reserved
    '{32'd6, 32'd1, 32'd1, 32'd3, 32'd13, 32'd0, 32'd1, 32'd1},  // R8 + R5
    '{32'd1, 32'd0, 32'd0, 32'd1, 32'd3,  32'd1, 32'd1, 32'd0}   // R3 compare 1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    we    = 1'b1;
    @(negedge clk);
    we    = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [AW-1:0] wa(input int ch, input int sub);
    return AW'(4 * ch + sub);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] hold;
    rst_n     = 1'b0;
    fast_tick = 1'b1;
    slow_tick = 1'b0;
    addr      = '0;
    wdata     = '0;
    we        = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_MASK, v);     check("R1 mask", v, 0);
    rd(A_PEND, v);     check("R1 pending", v, 0);
    rd(wa(1, 0), v);   check("R1 ctrl", v, 0);
    rd(wa(1, 1), v);   check("R1 cfg", v, 0);
    rd(wa(6, 2), v);   check("R1 counter", v, 0);
    rd(wa(6, 3), v);   check("R1 compare", v, 0);
    check("R1 irq", 32'(irq), 0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      int c;
      c = int'(VECS[k].ch);
      wr(A_PEND, 32'h3F);
      wr(wa(c, 1), VECS[k].div);
      wr(wa(c, 3), VECS[k].cmp);
      wr(wa(c, 0), (VECS[k].mode << 4) | 32'h3);
      repeat (int'(VECS[k].cyc)) @(negedge clk);
      rd(wa(c, 2), v);  check($sformatf("R3-vec%0d counter", k), v, VECS[k].ecnt);
      rd(A_PEND, v);    check($sformatf("R13 vec%0d pending", k), 32'(v[c-1]), VECS[k].epend);
      rd(wa(c, 0), v);  check($sformatf("R2 vec%0d ctrl", k), v, (VECS[k].mode << 4) | VECS[k].erun);
    end

    // R11 counter write ignored (ch1 halted at 1)
    wr(wa(1, 2), 32'h55);
    rd(wa(1, 2), v);   check("R11 counter write", v, 1);

    // R10 stop keeps mode, holds count
    wr(wa(3, 0), 32'h30);
    rd(wa(3, 0), v);   check("R10 ctrl readback", v, 32'h30);
    rd(wa(3, 2), hold);
    repeat (5) @(negedge clk);
    rd(wa(3, 2), v);   check("R10 held count", v, hold);

    // R7 clear beats step, bit 1 reads zero
    wr(wa(2, 0), 32'h13);
    rd(wa(2, 2), v);   check("R7 cleared", v, 0);
    rd(wa(2, 0), v);   check("R7 clear bit reads 0", v, 32'h11);
    repeat (3) @(negedge clk);
    rd(wa(2, 2), v);   check("R7 counts after clear", v, 3);

    // R12 / R13 masking and acknowledge
    for (int c = 1; c <= 6; c++) wr(wa(c, 0), 0);
    wr(A_PEND, 32'h3F);
    rd(A_PEND, v);     check("R13 all cleared", v, 0);
    check("R12 irq idle", 32'(irq), 0);
    wr(wa(5, 1), 0);
    wr(wa(5, 3), 2);
    wr(wa(5, 0), 32'h03);
    repeat (3) @(negedge clk);
    rd(A_PEND, v);     check("R13 flag set", v, 32'h10);
    check("R12 masked", 32'(irq), 0);
    wr(A_MASK, 32'h10);
    check("R12 unmasked", 32'(irq), 1);
    wr(A_PEND, 32'h01);
    rd(A_PEND, v);     check("R13 zero bit no effect", v, 32'h10);
    check("R12 still high", 32'(irq), 1);
    wr(A_PEND, 32'h10);
    rd(A_PEND, v);     check("R13 acked", v, 0);
    check("R12 low after ack", 32'(irq), 0);

    // R13 acknowledge racing a match
    wr(A_MASK, 32'h02);
    wr(wa(2, 3), 4);
    wr(wa(2, 0), 32'h13);
    repeat (7) @(negedge clk);
    wr(A_PEND, 32'h02);
    rd(A_PEND, v);     check("R13 match wins ack", v, 32'h02);
    check("R12 irq on race", 32'(irq), 1);
    wr(A_PEND, 32'h02);
    rd(A_PEND, v);     check("R13 later ack clears", v, 0);
    wr(wa(2, 0), 32'h10);

    // R9 slow source
    wr(wa(6, 1), 32'h10);
    rd(wa(6, 1), v);   check("R2 cfg readback", v, 32'h10);
    wr(wa(6, 0), 32'h33);
    repeat (5) @(negedge clk);
    rd(wa(6, 2), v);   check("R9 fast ignored", v, 0);
    for (int p = 0; p < 3; p++) begin
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      @(negedge clk);
    end
    rd(wa(6, 2), v);   check("R9 slow counted", v, 3);

    // R2 unmapped window
    wr(wa(7, 0), 32'h33);
    rd(wa(7, 0), v);   check("R2 unmapped", v, 0);
    rd(6'd1, v);       check("R2 shared gap", v, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule